// File: doc/BRIEF.md
# Self-Recovering Two-Phase Clock Sequencer

This block steps through four states in a fixed ring and produces two non-overlapping phase signals. It is meant to drive a two-phase clock generator. The state register uses a reduced one-hot code. The rest state (Home) is the all-zero vector, so three flip-flops cover four states. Each of the other three states sets exactly one bit.

The register is a plain shift chain. Its first stage is fed by the NOR of every state bit, so a new 1 enters only when the whole register is clear. This makes the machine recover on its own after a single-event upset:
- If an upset leaves surplus ones, they march down the chain and fall off the end.
- If an upset clears the only set bit, the machine lands in the legal Home state.

No separate illegal-state detector is needed.

The phase and home outputs are registered. Each one is decoded from the next-state value, so it lines up with the state it describes and changes only at a clock edge. The raw state vector is also brought out so the sequence can be observed.

Top module: `phase_seq_top`

## Requirements
- R1: An active-low asynchronous reset (rstN low) clears the state vector to 3'b000 at once, without waiting for a clock edge, and holds homePulse at 1 and phi1 and phi2 at 0 while asserted.
- R2: With no disturbance, the state vector advances once per rising clock edge through 3'b000 (Home), 3'b001 (One), 3'b010 (Two), 3'b100 (Three) and then back to 3'b000.
- R3: The state register is NUM_STATES-1 bits wide (3 bits by default). Home is encoded as all zeros and state k (k = 1..3) sets only bit k-1.
- R4: Bit 0 of the next state is 1 exactly when every bit of the current state is 0. Every other bit i takes the current value of bit i-1.
- R5: From any of the eight 3-bit register values, the state follows the R4 rule clock by clock and is one of 3'b000, 3'b001, 3'b010 or 3'b100 after at most three clocks.
- R6: If an upset clears the single set bit of a legal state, the register holds the legal Home code and continues with One on the next clock.
- R7: homePulse is 1 exactly when the state vector settled by the last clock edge is 3'b000.
- R8: phi1 is 1 only in state 3'b001 and phi2 only in state 3'b100, so the two are never 1 together. Neither phase output can be 1 in two consecutive cycles.
- R9: phi1, phi2 and homePulse are register outputs. A change of the state register between clock edges leaves them unchanged until the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| phi1 | output | 1 | First phase, high in state One |
| phi2 | output | 1 | Second phase, high in state Three |
| homePulse | output | 1 | High while the sequencer rests in Home |
| stateVec | output | 3 | Raw state register for observation |

## Verification
The bench drives the state register into each of the eight 3-bit values and follows the recovery clock by clock.
- A first stage fed by a bit-0 inverter instead of a full NOR would let a second one enter while surplus ones are still present, so a corrupted ring would never shed them.
- Clearing the single set bit while in state Two must fall back to Home and then restart at One. A design that treated all-zero as dead would stall there.
- A combinational phase decode would change its outputs mid-cycle when the register is disturbed, which the check for registered outputs catches.
- A reset tied to the clock would leave the state uncleared between edges, which the asynchronous-reset check catches.

// File: rtl/seq_pkg.sv
package seq_pkg;

  // Strobes handed from the control to the output datapath, decoded
  // from the value the state register takes at the coming edge.
  typedef struct packed {
    logic loadPh1;
    logic loadPh2;
    logic loadHome;
  } seqStrobe_t;

endpackage

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import seq_pkg::*;
#(
  parameter int NUM_STATES = 4,
  parameter int PH1_STATE  = 1,
  parameter int PH2_STATE  = 3,
  localparam int SW = NUM_STATES - 1
) (
  input  logic          clk,
  input  logic          rstN,
  output logic [SW-1:0] stateVec,
  output seqStrobe_t    strobe
);

  localparam logic [SW-1:0] PH1_CODE = SW'(1) << (PH1_STATE - 1);
  localparam logic [SW-1:0] PH2_CODE = SW'(1) << (PH2_STATE - 1);

  logic [SW-1:0] stateQ;
  logic [SW-1:0] stateD;

  // First stage refills only when the whole chain is empty.
  assign stateD[0] = ~|stateQ;

  // The remaining stages form a plain shift chain, so surplus ones
  // are pushed out of the top bit.
  generate
    for (genvar i = 1; i < SW; i++) begin : g_chain
      assign stateD[i] = stateQ[i-1];
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= '0;
    else       stateQ <= stateD;
  end

  always_comb begin
    strobe          = '0;
    strobe.loadPh1  = (stateD == PH1_CODE);
    strobe.loadPh2  = (stateD == PH2_CODE);
    strobe.loadHome = (stateD == '0);
  end

  assign stateVec = stateQ;

endmodule

// File: rtl/seq_datapath.sv
module seq_datapath
  import seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  seqStrobe_t strobe,
  output logic       phi1,
  output logic       phi2,
  output logic       homePulse
);

  logic phi1Q;
  logic phi2Q;
  logic homeQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phi1Q <= 1'b0;
      phi2Q <= 1'b0;
      homeQ <= 1'b1;
    end else begin
      phi1Q <= strobe.loadPh1;
      phi2Q <= strobe.loadPh2;
      homeQ <= strobe.loadHome;
    end
  end

  assign phi1      = phi1Q;
  assign phi2      = phi2Q;
  assign homePulse = homeQ;

endmodule

// File: rtl/phase_seq_top.sv
module phase_seq_top
  import seq_pkg::*;
#(
  parameter int NUM_STATES = 4,
  localparam int SW = NUM_STATES - 1
) (
  input  logic          clk,
  input  logic          rstN,
  output logic          phi1,
  output logic          phi2,
  output logic          homePulse,
  output logic [SW-1:0] stateVec
);

  seqStrobe_t strobe;

  seq_ctrl #(
    .NUM_STATES(NUM_STATES),
    .PH1_STATE (1),
    .PH2_STATE (NUM_STATES - 1)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .stateVec(stateVec),
    .strobe  (strobe)
  );

  seq_datapath u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .phi1     (phi1),
    .phi2     (phi2),
    .homePulse(homePulse)
  );

endmodule

// File: rtl/phase_seq_checker.sv
module phase_seq_checker #(
  parameter int SW = 3
) (
  input logic          clk,
  input logic          rstN,
  input logic          phi1,
  input logic          phi2,
  input logic          homePulse,
  input logic [SW-1:0] stateVec
);

  // R8: the two phases are never high together
  a_r8_phases_apart: assert property (@(posedge clk) disable iff (!rstN)
    !(phi1 && phi2));

  // R7 / R8: home and both phases are mutually exclusive outputs
  a_r7_outputs_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({phi1, phi2, homePulse}));

  // R1: leaving reset, the outputs show the Home state
  a_r1_reset_home: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (homePulse && !phi1 && !phi2));

  // R8: phase one never lasts two cycles
  a_r8_ph1_single: assert property (@(posedge clk) disable iff (!rstN)
    phi1 |=> !phi1);

  // R8: phase two never lasts two cycles
  a_r8_ph2_single: assert property (@(posedge clk) disable iff (!rstN)
    phi2 |=> !phi2);

endmodule

bind phase_seq_top phase_seq_checker #(.SW(SW)) u_checker (
  .clk      (clk),
  .rstN     (rstN),
  .phi1     (phi1),
  .phi2     (phi2),
  .homePulse(homePulse),
  .stateVec (stateVec)
);

// File: tb/phase_seq_top_bench.sv
`timescale 1ns/100ps
module phase_seq_top_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       phi1;
  logic       phi2;
  logic       homePulse;
  logic [2:0] stateVec;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  phase_seq_top u_phase_seq_top (
    .clk      (clk),
    .rstN     (rstN),
    .phi1     (phi1),
    .phi2     (phi2),
    .homePulse(homePulse),
    .stateVec (stateVec)
  );

  // Next-state rule from R4
  function automatic logic [2:0] nxt(input logic [2:0] v);
    return {v[1], v[0], ~|v};
  endfunction

  function automatic bit legal(input logic [2:0] v);
    return (v == 3'b000) || (v == 3'b001) || (v == 3'b010) || (v == 3'b100);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Compare every output against the decode of the expected state (R3, R7, R8)
  task automatic chkState(input string req, input logic [2:0] exp);
    chk(req, {29'd0, stateVec}, {29'd0, exp});
    chk({req, " R7 home"}, {31'd0, homePulse}, {31'd0, exp == 3'b000});
    chk({req, " R8 phi1"}, {31'd0, phi1}, {31'd0, exp == 3'b001});
    chk({req, " R8 phi2"}, {31'd0, phi2}, {31'd0, exp == 3'b100});
  endtask

  task automatic stepClk();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic inject(input logic [2:0] v);
    force u_phase_seq_top.u_ctrl.stateQ = v;
    #0.5;
    release u_phase_seq_top.u_ctrl.stateQ;
    #0.5;
  endtask

  task automatic goHome();
    for (int k = 0; k < 4; k++) begin
      if (stateVec == 3'b000) break;
      stepClk();
    end
  endtask

  task automatic testReset();
    rstN = 1'b0;
    #12;
    chkState("R1 reset state", 3'b000);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 release hold", {29'd0, stateVec}, 32'd1);
  endtask

  task automatic testCycle();
    logic [2:0] exp;
    goHome();
    exp = 3'b000;
    for (int k = 0; k < 8; k++) begin
      stepClk();
      exp = nxt(exp);
      chkState("R2 R3 ring order", exp);
    end
  endtask

  task automatic testRecovery();
    logic [2:0] exp;
    for (int v = 0; v < 8; v++) begin
      goHome();
      inject(3'(v));
      // R9: outputs still show Home until the next edge
      chk("R9 outputs held", {29'd0, homePulse, phi1, phi2}, 32'b100);
      exp = 3'(v);
      for (int k = 0; k < 3; k++) begin
        stepClk();
        exp = nxt(exp);
        chkState("R4 R5 recovery step", exp);
      end
      chk("R5 legal within three", {31'd0, legal(stateVec)}, 32'd1);
    end
  endtask

  task automatic testClearedBit();
    goHome();
    stepClk();
    stepClk();
    chkState("R6 at Two", 3'b010);
    inject(3'b000);
    stepClk();
    chkState("R6 after clear", 3'b001);
    stepClk();
    chkState("R6 resumes", 3'b010);
  endtask

  task automatic testAsyncReset();
    goHome();
    stepClk();
    stepClk();
    @(posedge clk);
    #1;
    rstN = 1'b0;
    #0.5;
    chk("R1 async clear", {29'd0, stateVec}, 32'd0);
    chk("R1 async home", {31'd0, homePulse}, 32'd1);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chkState("R1 restart", 3'b001);
  endtask

  initial begin
    testReset();
    testCycle();
    testRecovery();
    testClearedBit();
    testAsyncReset();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule